// File: doc/BRIEF.md
# Dual Comparator Breakpoint Unit

The unit watches every bus cycle of a processor: a 16-bit address, whether the cycle targets memory or the I/O space, and whether it reads or writes. Two address comparators, A and B, each hold a reference address and a 4-bit cycle-type qualifier. A 4-bit relation code joins the two into one break condition. The relation can be either comparator alone, B after an earlier A, an address inside the span A..B, or an address outside it.

Every bus cycle that meets the condition is flagged one clock later on a hit output, so a trace recorder can mark it. When stopping is armed, a detected condition is held as pending until the processor reports an instruction boundary. The unit then raises a break request, which stays high until the pause is acknowledged. Software or a front panel loads the configuration through a small register write port. Arming can change at any time while the program runs.

Top module: `bkpt_pair_unit`

## Requirements
- R1: After reset the relation is C, both qualifiers are 3, both addresses are 0000, and brk_req and cyc_hit are low.
- R2: A write with cfg_wr high loads the register picked by cfg_sel: 0 address A, 1 address B, 2 qualifier A (cfg_data[3:0]), 3 qualifier B (cfg_data[3:0]), 4 relation (cfg_data[3:0]). Any other cfg_sel value changes nothing.
- R3: Qualifier bit 2 picks the space (0 memory, 1 I/O), bit 0 allows reads and bit 1 allows writes. Codes 0 and 4, and every code from 8 to F, match no cycle.
- R4: An I/O cycle compares only address bits 7:0. A memory cycle compares all 16 bits.
- R5: Relation C, and any relation value other than D, E or F, detects a cycle that matches A (address and qualifier) or matches B.
- R6: Relation D detects a B match only when an A match happened in an earlier bus cycle. An A match in the same cycle does not count.
- R7: The "A seen" state of relation D is cleared by a rising edge of arm, by any configuration write, and by a break firing in relation D.
- R8: Relation E detects A <= address <= B. It uses one shared qualifier: qualifier A if it is 1, 2, 3, 5, 6 or 7, otherwise qualifier B.
- R9: Relation F detects address <= A or address >= B, so both bounds are included. It uses the same shared qualifier as R8.
- R10: cyc_hit is high in the clock after a bus cycle that meets the condition, whether or not the unit is armed, and is low otherwise.
- R11: brk_req rises at the clock edge where instr_end is high, arm is high, and a condition was met since the last boundary or in that same cycle. It then stays high until pause_ack, which clears it at the next edge.
- R12: No break request forms while arm is low, and dropping arm discards a pending condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_data | input | 16 | Write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | Bus cycle address |
| bus_io | input | 1 | 1 for an I/O cycle, 0 for memory |
| bus_rd | input | 1 | Cycle reads |
| bus_wr | input | 1 | Cycle writes |
| arm | input | 1 | Stop on break condition enabled |
| instr_end | input | 1 | Last clock of the current instruction |
| pause_ack | input | 1 | Processor has paused; clears the request |
| brk_req | output | 1 | Break request, held until acknowledged |
| cyc_hit | output | 1 | Previous bus cycle met the condition |

## Verification
The comparator table mixes several cases. It pairs matching addresses with the wrong direction or the wrong space, which separates address equality from qualifier decoding. It uses I/O cycles whose upper address byte differs from the reference, which shows whether the narrow port compare is in effect. Range cases sit exactly on, and one step past, each bound, which exposes off-by-one and inclusive/exclusive mix-ups. In these cases the qualifier of A and the qualifier of B disagree, which shows which qualifier the shared range type comes from. Ordered tests present B before A, A and B in the same cycle, and A followed by re-arming or a configuration write, so each way of clearing the sequence state is seen on its own. Request tests place the hit before the boundary, on the boundary clock, and before a disarm, which separates pending, immediate and discarded conditions.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   // relation codes
   localparam logic [3:0] REL_EITHER  = 4'hC;
   localparam logic [3:0] REL_ORDERED = 4'hD;
   localparam logic [3:0] REL_INSIDE  = 4'hE;
   localparam logic [3:0] REL_OUTSIDE = 4'hF;

   // configuration register selects
   localparam logic [2:0] SEL_ADDR_A = 3'd0;
   localparam logic [2:0] SEL_ADDR_B = 3'd1;
   localparam logic [2:0] SEL_QUAL_A = 3'd2;
   localparam logic [2:0] SEL_QUAL_B = 3'd3;
   localparam logic [2:0] SEL_REL    = 3'd4;

   // reset qualifier: memory read or write
   localparam int unsigned QUAL_RESET = 3;
endpackage

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
   parameter int ADDR_W    = 16,
   parameter int PORT_W    = 8,
   parameter bit IO_NARROW = 1'b1
) (
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              is_io,
   output logic              eq,
   output logic              bus_ge,
   output logic              bus_le
);
   localparam logic [ADDR_W-1:0] FULL_MASK = '1;
   localparam logic [ADDR_W-1:0] IO_MASK   =
      IO_NARROW ? FULL_MASK >> (ADDR_W - PORT_W) : FULL_MASK;

   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] r_m;
   logic [ADDR_W-1:0] b_m;

   assign mask   = is_io ? IO_MASK : FULL_MASK;
   assign r_m    = ref_addr & mask;
   assign b_m    = bus_addr & mask;
   assign eq     = (r_m == b_m);
   assign bus_ge = (b_m >= r_m);
   assign bus_le = (b_m <= r_m);
endmodule

// File: rtl/bkpt_kind_match.sv
module bkpt_kind_match #(
   parameter int QUAL_W = 4
) (
   input  logic [QUAL_W-1:0] qual,
   input  logic              is_io,
   input  logic              rd,
   input  logic              wr,
   output logic              hit
);
   logic hi_zero;

   generate
      if (QUAL_W > 3) begin : g_hi
         assign hi_zero = ~|qual[QUAL_W-1:3];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign hit = hi_zero && (qual[2] == is_io) && ((qual[0] && rd) || (qual[1] && wr));
endmodule

// File: rtl/bkpt_stop_ctrl.sv
module bkpt_stop_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic seq_mode,
   input  logic a_cyc,
   input  logic cfg_touch,
   input  logic arm,
   input  logic instr_end,
   input  logic pause_ack,
   output logic seq_q,
   output logic brk_q,
   output logic hit_q
);
   logic arm_q;
   logic pend_q;
   logic rearm;
   logic fire;

   assign rearm = arm && !arm_q;
   assign fire  = cond && arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         seq_q  <= 1'b0;
         pend_q <= 1'b0;
         brk_q  <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         arm_q <= arm;
         hit_q <= cond;

         if (rearm || cfg_touch || (seq_mode && fire))
            seq_q <= 1'b0;
         else if (seq_mode && a_cyc)
            seq_q <= 1'b1;

         if (pause_ack || !arm || brk_q || instr_end)
            pend_q <= 1'b0;
         else if (fire)
            pend_q <= 1'b1;

         if (pause_ack)
            brk_q <= 1'b0;
         else if (instr_end && arm && (pend_q || fire))
            brk_q <= 1'b1;
      end
   end
endmodule

// File: rtl/bkpt_pair_unit.sv
module bkpt_pair_unit
   import bkpt_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PORT_W    = 8,
   parameter int QUAL_W    = 4,
   parameter bit IO_NARROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_io,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              arm,
   input  logic              instr_end,
   input  logic              pause_ack,
   output logic              brk_req,
   output logic              cyc_hit
);
   localparam int NCMP   = 2;
   localparam int REL_W  = 4;

   generate
      if (PORT_W > ADDR_W || PORT_W < 1) begin : g_bad_port
         $error("PORT_W must lie in 1..ADDR_W");
      end
      if (QUAL_W < 4 || QUAL_W > ADDR_W) begin : g_bad_qual
         $error("QUAL_W must lie in 4..ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q [NCMP];
   logic [QUAL_W-1:0] qual_q [NCMP];
   logic [REL_W-1:0]  rel_q;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCMP; i++) begin
            addr_q[i] <= '0;
            qual_q[i] <= QUAL_W'(QUAL_RESET);
         end
         rel_q <= REL_EITHER;
      end else if (cfg_wr) begin
         case (cfg_sel)
            SEL_ADDR_A: addr_q[0] <= cfg_data;
            SEL_ADDR_B: addr_q[1] <= cfg_data;
            SEL_QUAL_A: qual_q[0] <= cfg_data[QUAL_W-1:0];
            SEL_QUAL_B: qual_q[1] <= cfg_data[QUAL_W-1:0];
            SEL_REL:    rel_q     <= cfg_data[REL_W-1:0];
            default:    ;
         endcase
      end
   end

   logic [NCMP-1:0] eq;
   logic [NCMP-1:0] ge;
   logic [NCMP-1:0] le;
   logic [NCMP-1:0] kind;
   logic [NCMP-1:0] hit;

   generate
      for (genvar g = 0; g < NCMP; g++) begin : g_cmp
         bkpt_addr_cmp #(
            .ADDR_W   (ADDR_W),
            .PORT_W   (PORT_W),
            .IO_NARROW(IO_NARROW)
         ) i_addr (
            .ref_addr(addr_q[g]),
            .bus_addr(bus_addr),
            .is_io   (bus_io),
            .eq      (eq[g]),
            .bus_ge  (ge[g]),
            .bus_le  (le[g])
         );
         bkpt_kind_match #(.QUAL_W(QUAL_W)) i_kind (
            .qual (qual_q[g]),
            .is_io(bus_io),
            .rd   (bus_rd),
            .wr   (bus_wr),
            .hit  (kind[g])
         );
         assign hit[g] = bus_valid && eq[g] && kind[g];
      end
   endgenerate

   // shared qualifier for the span relations
   logic              a_live;
   logic [QUAL_W-1:0] qual_sh;
   logic              kind_sh;

   assign a_live  = (qual_q[0] < QUAL_W'(8)) && (|qual_q[0][1:0]);
   assign qual_sh = a_live ? qual_q[0] : qual_q[1];

   bkpt_kind_match #(.QUAL_W(QUAL_W)) i_kind_sh (
      .qual (qual_sh),
      .is_io(bus_io),
      .rd   (bus_rd),
      .wr   (bus_wr),
      .hit  (kind_sh)
   );

   logic seq_q;
   logic cond_raw;
   logic cond;

   always_comb begin
      case (rel_q)
         REL_ORDERED: cond_raw = hit[1] && seq_q;
         REL_INSIDE:  cond_raw = kind_sh && ge[0] && le[1];
         REL_OUTSIDE: cond_raw = kind_sh && (le[0] || ge[1]);
         default:     cond_raw = hit[0] || hit[1];
      endcase
   end

   assign cond = bus_valid && cond_raw;

   bkpt_stop_ctrl i_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond     (cond),
      .seq_mode (rel_q == REL_ORDERED),
      .a_cyc    (hit[0]),
      .cfg_touch(cfg_wr),
      .arm      (arm),
      .instr_end(instr_end),
      .pause_ack(pause_ack),
      .seq_q    (seq_q),
      .brk_q    (brk_req),
      .hit_q    (cyc_hit)
   );
endmodule

// File: rtl/bkpt_pair_unit_chk.sv
module bkpt_pair_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_valid,
   input logic arm,
   input logic instr_end,
   input logic pause_ack,
   input logic brk_req,
   input logic cyc_hit
);
   // R11: request holds until acknowledged
   a_r11_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req && !pause_ack |=> brk_req);

   // R11: acknowledge clears the request
   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pause_ack |=> !brk_req);

   // R11: a request only appears at an armed instruction boundary
   a_r11_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_req) |-> ($past(instr_end) && $past(arm)));

   // R12: unarmed unit never starts a request
   a_r12_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !brk_req) |=> !brk_req);

   // R10: a hit flag follows a real bus cycle
   a_r10_hit_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_hit |-> $past(bus_valid));
endmodule

bind bkpt_pair_unit bkpt_pair_unit_chk i_bkpt_chk (.*);

// File: tb/test_bkpt_pair_unit.sv
module test_bkpt_pair_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 18;

   // {rel, qual A, qual B, addr A, addr B, bus addr, io, rd, wr, expected hit}
   localparam logic [63:0] VEC [NVEC] = '{
      {4'hC, 4'h3, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R5
      {4'hC, 4'h1, 4'h0, 16'h8A72, 16'h0000, 16'h8A72, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 dir
      {4'hC, 4'h1, 4'h0, 16'h8A72, 16'h0000, 16'h8A72, 1'b0, 1'b1, 1'b0, 1'b1}, // R3
      {4'hC, 4'h0, 4'h6, 16'h0000, 16'h0013, 16'h0013, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 B
      {4'hC, 4'h0, 4'h6, 16'h0000, 16'h0013, 16'hAB13, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
      {4'hC, 4'h0, 4'h2, 16'h0000, 16'h0013, 16'hAB13, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 mem
      {4'hC, 4'h4, 4'h4, 16'h1234, 16'h1234, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 code4
      {4'hC, 4'h5, 4'h0, 16'h0040, 16'h0000, 16'h0040, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 space
      {4'hE, 4'h0, 4'h2, 16'h4307, 16'hFFFF, 16'h4307, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 lo
      {4'hE, 4'h2, 4'h0, 16'h4307, 16'hFFFF, 16'h4306, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 below
      {4'hE, 4'h2, 4'h1, 16'h4307, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 A qual
      {4'hE, 4'h2, 4'h1, 16'h4307, 16'hFFFF, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 not B
      {4'hF, 4'h3, 4'h0, 16'h1000, 16'h2000, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b1}, // R9 A
      {4'hF, 4'h3, 4'h0, 16'h1000, 16'h2000, 16'h1800, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 in
      {4'hF, 4'h3, 4'h0, 16'h1000, 16'h2000, 16'h2000, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 B
      {4'hF, 4'h3, 4'h0, 16'h1000, 16'h2000, 16'h0FFF, 1'b0, 1'b1, 1'b0, 1'b1}, // R9 low
      {4'h0, 4'h3, 4'h0, 16'h5555, 16'h0000, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 rel0
      {4'hC, 4'h3, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0}  // R3 io
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic        bus_valid = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_io = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic        arm = 1'b0;
   logic        instr_end = 1'b0;
   logic        pause_ack = 1'b0;
   logic        brk_req;
   logic        cyc_hit;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bkpt_pair_unit i_bkpt_pair_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_io(bus_io), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .arm(arm), .instr_end(instr_end), .pause_ack(pause_ack),
      .brk_req(brk_req), .cyc_hit(cyc_hit)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [15:0] data);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_cfg(input logic [3:0] rel, input logic [3:0] qa, input logic [3:0] qb,
                          input logic [15:0] aa, input logic [15:0] ab);
      cfg_write(3'd0, aa);
      cfg_write(3'd1, ab);
      cfg_write(3'd2, {12'h0, qa});
      cfg_write(3'd3, {12'h0, qb});
      cfg_write(3'd4, {12'h0, rel});
   endtask

   task automatic bus(input logic [15:0] a, input logic io, input logic rd, input logic wr);
      bus_valid = 1'b1; bus_addr = a; bus_io = io; bus_rd = rd; bus_wr = wr;
      @(negedge clk);
      bus_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic boundary();
      instr_end = 1'b1;
      @(negedge clk);
      instr_end = 1'b0;
   endtask

   task automatic ack();
      pause_ack = 1'b1;
      @(negedge clk);
      pause_ack = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 brk_req in reset", brk_req, 1'b0);
      check("R1 cyc_hit in reset", cyc_hit, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 brk_req after reset", brk_req, 1'b0);

      // R1 defaults: A or B, memory read/write, address 0000
      bus(16'h0000, 1'b0, 1'b1, 1'b0);
      check("R1 default mem read 0000", cyc_hit, 1'b1);
      bus(16'h0000, 1'b0, 1'b0, 1'b1);
      check("R1 default mem write 0000", cyc_hit, 1'b1);
      bus(16'h0001, 1'b0, 1'b1, 1'b0);
      check("R1 default other address", cyc_hit, 1'b0);
      bus(16'h0000, 1'b1, 1'b1, 1'b0);
      check("R1 default io cycle", cyc_hit, 1'b0);
      @(negedge clk);
      check("R10 hit drops without cycle", cyc_hit, 1'b0);

      // table of comparator cases, unarmed (R10 hit independent of arm)
      for (int i = 0; i < NVEC; i++) begin
         set_cfg(VEC[i][63:60], VEC[i][59:56], VEC[i][55:52], VEC[i][51:36], VEC[i][35:20]);
         bus(VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1]);
         check($sformatf("R10 vector %0d", i), cyc_hit, VEC[i][0]);
      end

      // R2: undefined selects change nothing
      set_cfg(4'hC, 4'h3, 4'h0, 16'h0100, 16'h0000);
      cfg_write(3'd5, 16'h0000);
      cfg_write(3'd7, 16'hFFFF);
      bus(16'h0100, 1'b0, 1'b1, 1'b0);
      check("R2 unused select ignored", cyc_hit, 1'b1);

      // R6: ordered relation
      set_cfg(4'hD, 4'h1, 4'h6, 16'hEB22, 16'h0048);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R6 B before A", cyc_hit, 1'b0);
      bus(16'hEB22, 1'b0, 1'b1, 1'b0);
      check("R6 A alone", cyc_hit, 1'b0);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R6 B after A", cyc_hit, 1'b1);

      set_cfg(4'hD, 4'h7, 4'h7, 16'h0048, 16'h0048);
      bus(16'h0048, 1'b1, 1'b1, 1'b0);
      check("R6 A and B same cycle", cyc_hit, 1'b0);
      bus(16'h0048, 1'b1, 1'b1, 1'b0);
      check("R6 B after same-cycle A", cyc_hit, 1'b1);

      // R7: clearing of the A-seen state
      set_cfg(4'hD, 4'h1, 4'h6, 16'hEB22, 16'h0048);
      bus(16'hEB22, 1'b0, 1'b1, 1'b0);
      cfg_write(3'd1, 16'h0048);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R7 config write clears", cyc_hit, 1'b0);

      bus(16'hEB22, 1'b0, 1'b1, 1'b0);
      arm = 1'b1;
      @(negedge clk);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R7 re-arm clears", cyc_hit, 1'b0);
      bus(16'hEB22, 1'b0, 1'b1, 1'b0);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R7 armed ordered hit", cyc_hit, 1'b1);
      bus(16'h0048, 1'b1, 1'b0, 1'b1);
      check("R7 fired break clears", cyc_hit, 1'b0);
      arm = 1'b0;
      @(negedge clk);
      boundary();
      check("R12 disarm drops ordered pending", brk_req, 1'b0);

      // R11: pending until boundary, held until acknowledge
      set_cfg(4'hC, 4'h3, 4'h0, 16'h2000, 16'h0000);
      arm = 1'b1;
      @(negedge clk);
      bus(16'h2000, 1'b0, 1'b1, 1'b0);
      check("R11 no request before boundary", brk_req, 1'b0);
      @(negedge clk);
      check("R11 still waiting", brk_req, 1'b0);
      boundary();
      check("R11 request at boundary", brk_req, 1'b1);
      repeat (3) @(negedge clk);
      check("R11 request held", brk_req, 1'b1);
      ack();
      check("R11 acknowledge clears", brk_req, 1'b0);
      boundary();
      check("R11 no repeat after ack", brk_req, 1'b0);

      // R11: hit on the boundary clock itself
      bus_valid = 1'b1; bus_addr = 16'h2000; bus_io = 1'b0; bus_rd = 1'b1; instr_end = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; bus_rd = 1'b0; instr_end = 1'b0;
      check("R11 same-cycle boundary", brk_req, 1'b1);
      ack();

      // R12: unarmed and disarmed behaviour
      arm = 1'b0;
      @(negedge clk);
      bus(16'h2000, 1'b0, 1'b1, 1'b0);
      check("R12 unarmed hit still flagged", cyc_hit, 1'b1);
      boundary();
      check("R12 unarmed no request", brk_req, 1'b0);
      arm = 1'b1;
      @(negedge clk);
      bus(16'h2000, 1'b0, 1'b1, 1'b0);
      arm = 1'b0;
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      boundary();
      check("R12 disarm discards pending", brk_req, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule